// File: doc/BRIEF.md
# Spiking Neuron Control Register Block

This block is an AXI4-Lite slave that places a single spiking-neuron core under software control. Software writes a two-bit control word, a signed input current and three signed model parameters: resting level, firing threshold and membrane time constant. Each of these is held in a register and driven straight onto the core's inputs. Software reads back every register through the same interface.

The core reports each spike with a one-cycle strobe. The block counts those strobes in a saturating counter that software can only read. It also turns each counted spike into a one-cycle interrupt pulse that can go to a system interrupt controller.

The control word has two bits. One gates the core, and both the counter and the interrupt. The other holds the core in reset and keeps the counter at zero for as long as it stays set.

Top module: `nc_ctrl_axil`

## Requirements
- R1: After the bus reset (rst_ni low), every register reads zero. `core_en_o`, `core_rst_o`, `irq_spike_o` and all parameter outputs are zero, and no bus response is pending.
- R2: The registers sit on word offsets. 0x00 is control, 0x04 is drive current, 0x08 is the spike count, 0x0C is resting level, 0x10 is threshold and 0x14 is time constant. Address bits [1:0] are ignored. A value register stores the low VAL_W bits of a write, drives its output port, and reads back sign-extended to 32 bits.
- R3: Control bit 0 drives `core_en_o` and control bit 1 drives `core_rst_o`. Each is held as a level for as long as the bit stays set. The other control bits read as zero.
- R4: The spike count goes up by one at each clock edge where `spike_i` is high, bit 0 is set and bit 1 is clear. Otherwise it holds. It reads back zero-extended.
- R5: While control bit 1 is set, the spike count is forced to zero, whatever bit 0 holds.
- R6: The spike count stops at all-ones (2^CNT_W-1) and never wraps.
- R7: A write to offset 0x08, or to any offset above 0x14, completes with response OKAY (2'b00) and changes nothing. A read from an offset above 0x14 returns zero.
- R8: `irq_spike_o` is high for exactly the one cycle after a cycle where `spike_i` was high with bit 0 set and bit 1 clear. At all other times it is low.
- R9: Write address and write data are accepted in either order or together. Each write gives exactly one B response with OKAY (2'b00), and `s_bvalid_o` stays high until `s_bready_i` is seen.
- R10: Byte lane n of a write (wstrb bit n, data bits 8n+7..8n) updates only bits 8n+7..8n of the register. For a value register, lanes above VAL_W bits are dropped. The control word takes only lane 0.
- R11: Each accepted read address gives exactly one R response with OKAY (2'b00). `s_rvalid_o` and `s_rdata_o` hold until `s_rready_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| s_awaddr_i | input | AW | Write address |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | 32 | Write data |
| s_wstrb_i | input | 4 | Write byte strobes |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bresp_o | output | 2 | Write response, always OKAY |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | AW | Read address |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | 32 | Read data |
| s_rresp_o | output | 2 | Read response, always OKAY |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |
| core_en_o | output | 1 | Core enable (control bit 0) |
| core_rst_o | output | 1 | Core reset level (control bit 1) |
| drive_cur_o | output | VAL_W | Signed input current to the core |
| rest_lvl_o | output | VAL_W | Signed resting level |
| fire_lvl_o | output | VAL_W | Signed firing threshold |
| leak_tc_o | output | VAL_W | Membrane time constant |
| spike_i | input | 1 | One-cycle spike strobe from the core |
| irq_spike_o | output | 1 | One-cycle spike interrupt pulse |

## Verification
The hardest state to reach is the counter pinned at all-ones while spikes keep arriving. With a 32-bit count that takes billions of cycles. The bench therefore builds the block with an 8-bit counter and holds the strobe high for more than 256 enabled cycles, so the count must stop at 255.

A second awkward case is a control write that lands while spikes are in flight. The reference model updates its own control copy only in the cycle the B response appears, which is the cycle the register changed. It then compares the enable, reset and interrupt outputs against the model on every clock.

// File: rtl/nc_pkg.sv
package nc_pkg;
  localparam int BUS_W    = 32;
  localparam int IDX_CTRL = 0;
  localparam int IDX_CNT  = 2;
  localparam int IDX_LAST = 5;
  localparam logic [1:0] RESP_OKAY = 2'b00;

  // word index of value register g: current, rest, threshold, time constant
  function automatic int par_idx(input int g);
    case (g)
      0:       return 1;
      1:       return 3;
      2:       return 4;
      default: return 5;
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] strb_merge(input logic [BUS_W-1:0] old_v,
                                                  input logic [BUS_W-1:0] new_v,
                                                  input logic [BUS_W/8-1:0] strb);
    logic [BUS_W-1:0] r;
    for (int b = 0; b < BUS_W/8; b++)
      r[8*b +: 8] = strb[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/nc_axil_wr.sv
module nc_axil_wr import nc_pkg::*; #(
  parameter int AW = 8,
  localparam int IDX_W = AW - 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      awaddr_i,
  input  logic               awvalid_i,
  output logic               awready_o,
  input  logic [BUS_W-1:0]   wdata_i,
  input  logic [BUS_W/8-1:0] wstrb_i,
  input  logic               wvalid_i,
  output logic               wready_o,
  output logic               bvalid_o,
  input  logic               bready_i,
  output logic               we_o,
  output logic [IDX_W-1:0]   widx_o,
  output logic [BUS_W-1:0]   wdata_o,
  output logic [BUS_W/8-1:0] wstrb_o
);
  logic aw_hold, w_hold, bvalid_q;
  logic unused_aw_lsb;

  assign unused_aw_lsb = ^awaddr_i[1:0];
  assign awready_o = !aw_hold && !bvalid_q;
  assign wready_o  = !w_hold && !bvalid_q;
  assign we_o      = aw_hold && w_hold;
  assign bvalid_o  = bvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_hold  <= 1'b0;
      w_hold   <= 1'b0;
      bvalid_q <= 1'b0;
      widx_o   <= '0;
      wdata_o  <= '0;
      wstrb_o  <= '0;
    end else begin
      if (awvalid_i && awready_o) begin
        aw_hold <= 1'b1;
        widx_o  <= awaddr_i[AW-1:2];
      end
      if (wvalid_i && wready_o) begin
        w_hold  <= 1'b1;
        wdata_o <= wdata_i;
        wstrb_o <= wstrb_i;
      end
      if (we_o) begin
        aw_hold  <= 1'b0;
        w_hold   <= 1'b0;
        bvalid_q <= 1'b1;
      end else if (bvalid_q && bready_i) begin
        bvalid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nc_axil_rd.sv
module nc_axil_rd import nc_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arvalid_i,
  output logic             arready_o,
  input  logic [BUS_W-1:0] rd_word_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             rvalid_o,
  input  logic             rready_i
);
  assign arready_o = !rvalid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else if (arvalid_i && arready_o) begin
      rvalid_o <= 1'b1;
      rdata_o  <= rd_word_i;
    end else if (rvalid_o && rready_i) begin
      rvalid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/nc_spike_cnt.sv
module nc_spike_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             spike_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  logic live;
  assign live = spike_i && en_i && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= live;
      if (clr_i)                       cnt_o <= '0;
      else if (live && (cnt_o != '1))  cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/nc_ctrl_axil.sv
module nc_ctrl_axil import nc_pkg::*; #(
  parameter int AW    = 8,
  parameter int VAL_W = 16,
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    s_awaddr_i,
  input  logic             s_awvalid_i,
  output logic             s_awready_o,
  input  logic [31:0]      s_wdata_i,
  input  logic [3:0]       s_wstrb_i,
  input  logic             s_wvalid_i,
  output logic             s_wready_o,
  output logic [1:0]       s_bresp_o,
  output logic             s_bvalid_o,
  input  logic             s_bready_i,
  input  logic [AW-1:0]    s_araddr_i,
  input  logic             s_arvalid_i,
  output logic             s_arready_o,
  output logic [31:0]      s_rdata_o,
  output logic [1:0]       s_rresp_o,
  output logic             s_rvalid_o,
  input  logic             s_rready_i,
  output logic             core_en_o,
  output logic             core_rst_o,
  output logic [VAL_W-1:0] drive_cur_o,
  output logic [VAL_W-1:0] rest_lvl_o,
  output logic [VAL_W-1:0] fire_lvl_o,
  output logic [VAL_W-1:0] leak_tc_o,
  input  logic             spike_i,
  output logic             irq_spike_o
);
  localparam int IDX_W = AW - 2;
  localparam int NPAR  = 4;
  localparam logic [IDX_W-1:0] I_CTRL = IDX_W'(IDX_CTRL);
  localparam logic [IDX_W-1:0] I_CNT  = IDX_W'(IDX_CNT);

  logic             we;
  logic [IDX_W-1:0] widx, ridx;
  logic [31:0]      wdat, rd_word;
  logic [3:0]       wstb;
  logic [1:0]       ctrl_q;
  logic [VAL_W-1:0] par_q [NPAR];
  logic [CNT_W-1:0] spike_cnt;
  logic             unused_ar_lsb;

  function automatic logic [31:0] sext(input logic [VAL_W-1:0] v);
    return 32'($signed(v));
  endfunction

  nc_axil_wr #(.AW(AW)) u_wr (
    .clk_i, .rst_ni,
    .awaddr_i(s_awaddr_i), .awvalid_i(s_awvalid_i), .awready_o(s_awready_o),
    .wdata_i(s_wdata_i), .wstrb_i(s_wstrb_i), .wvalid_i(s_wvalid_i), .wready_o(s_wready_o),
    .bvalid_o(s_bvalid_o), .bready_i(s_bready_i),
    .we_o(we), .widx_o(widx), .wdata_o(wdat), .wstrb_o(wstb)
  );

  nc_axil_rd u_rd (
    .clk_i, .rst_ni,
    .arvalid_i(s_arvalid_i), .arready_o(s_arready_o),
    .rd_word_i(rd_word), .rdata_o(s_rdata_o),
    .rvalid_o(s_rvalid_o), .rready_i(s_rready_i)
  );

  nc_spike_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .en_i(ctrl_q[0]), .clr_i(ctrl_q[1]), .spike_i,
    .cnt_o(spike_cnt), .irq_o(irq_spike_o)
  );

  assign s_bresp_o = RESP_OKAY;
  assign s_rresp_o = RESP_OKAY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               ctrl_q <= '0;
    else if (we && widx == I_CTRL && wstb[0])  ctrl_q <= wdat[1:0];
  end

  for (genvar g = 0; g < NPAR; g++) begin : g_par
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(par_idx(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    par_q[g] <= '0;
      else if (we && widx == MY_IDX)  par_q[g] <= VAL_W'(strb_merge(sext(par_q[g]), wdat, wstb));
    end
  end

  assign ridx          = s_araddr_i[AW-1:2];
  assign unused_ar_lsb = ^s_araddr_i[1:0];

  always_comb begin
    rd_word = '0;
    if (ridx == I_CTRL) rd_word = {30'b0, ctrl_q};
    if (ridx == I_CNT)  rd_word = 32'(spike_cnt);
    for (int k = 0; k < NPAR; k++)
      if (ridx == IDX_W'(par_idx(k))) rd_word = sext(par_q[k]);
  end

  assign core_en_o   = ctrl_q[0];
  assign core_rst_o  = ctrl_q[1];
  assign drive_cur_o = par_q[0];
  assign rest_lvl_o  = par_q[1];
  assign fire_lvl_o  = par_q[2];
  assign leak_tc_o   = par_q[3];
endmodule

// File: rtl/nc_ctrl_axil_chk.sv
module nc_ctrl_axil_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             spike_i,
  input logic             core_en_i,
  input logic             core_rst_i,
  input logic             irq_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             bvalid_i,
  input logic             bready_i,
  input logic             rvalid_i,
  input logic             rready_i
);
  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_i |=> (cnt_i == '0)); // R5
  AST_CNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_en_i && !core_rst_i) |=> $stable(cnt_i)); // R4
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spike_i && core_en_i && !core_rst_i && cnt_i != '1) |=> (cnt_i == $past(cnt_i) + CNT_W'(1))); // R4
  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '1 && !core_rst_i) |=> (cnt_i == '1)); // R6
  AST_IRQ_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spike_i && core_en_i && !core_rst_i) |=> irq_i); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!spike_i || !core_en_i || core_rst_i) |=> !irq_i); // R8
  AST_B_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bvalid_i && !bready_i) |=> bvalid_i); // R9
  AST_B_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bvalid_i && bready_i) |=> !bvalid_i); // R9
  AST_R_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_i && !rready_i) |=> rvalid_i); // R11
  AST_R_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_i && rready_i) |=> !rvalid_i); // R11
endmodule

bind nc_ctrl_axil nc_ctrl_axil_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .spike_i(spike_i),
  .core_en_i(core_en_o), .core_rst_i(core_rst_o), .irq_i(irq_spike_o),
  .cnt_i(spike_cnt), .bvalid_i(s_bvalid_o), .bready_i(s_bready_i),
  .rvalid_i(s_rvalid_o), .rready_i(s_rready_i)
);

// File: tb/nc_ctrl_axil_tb.sv
module nc_ctrl_axil_tb;
  localparam int CW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1, spike = 0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        awready, wready, bvalid, arready, rvalid, core_en, core_rst, irq;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic [15:0] cur, rest, thr, tau;

  int n_chk = 0, n_fail = 0;
  logic [1:0]    m_ctrl = '0;
  logic [15:0]   m_reg [8];
  logic [CW-1:0] m_cnt = '0;
  logic          m_irq = 0;

  always #10 clk = ~clk;

  nc_ctrl_axil #(.AW(8), .VAL_W(16), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .s_awaddr_i(awaddr), .s_awvalid_i(awvalid), .s_awready_o(awready),
    .s_wdata_i(wdata), .s_wstrb_i(wstrb), .s_wvalid_i(wvalid), .s_wready_o(wready),
    .s_bresp_o(bresp), .s_bvalid_o(bvalid), .s_bready_i(bready),
    .s_araddr_i(araddr), .s_arvalid_i(arvalid), .s_arready_o(arready),
    .s_rdata_o(rdata), .s_rresp_o(rresp), .s_rvalid_o(rvalid), .s_rready_i(rready),
    .core_en_o(core_en), .core_rst_o(core_rst),
    .drive_cur_o(cur), .rest_lvl_o(rest), .fire_lvl_o(thr), .leak_tc_o(tau),
    .spike_i(spike), .irq_spike_o(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // behavioural reference: counter and interrupt advance on each edge
  always @(posedge clk) begin
    if (rst_n) begin
      m_irq <= spike && m_ctrl[0] && !m_ctrl[1];
      if (m_ctrl[1]) m_cnt <= '0;
      else if (spike && m_ctrl[0] && m_cnt != '1) m_cnt <= m_cnt + 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      #2;
      check(core_en  === m_ctrl[0], "R3 core_en",  32'(core_en),  32'(m_ctrl[0]));
      check(core_rst === m_ctrl[1], "R3 core_rst", 32'(core_rst), 32'(m_ctrl[1]));
      check(irq === m_irq, "R8 irq", 32'(irq), 32'(m_irq));
      check(cur  === m_reg[1], "R2 drive_cur", 32'(cur),  32'(m_reg[1]));
      check(rest === m_reg[3], "R2 rest_lvl",  32'(rest), 32'(m_reg[3]));
      check(thr  === m_reg[4], "R2 fire_lvl",  32'(thr),  32'(m_reg[4]));
      check(tau  === m_reg[5], "R2 leak_tc",   32'(tau),  32'(m_reg[5]));
    end
  end

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    int i = int'(a[7:2]);
    if (i == 0) return {30'b0, m_ctrl};
    if (i == 2) return {24'b0, m_cnt};
    if (i == 1 || i == 3 || i == 4 || i == 5) return sx(m_reg[i]);
    return 32'h0;
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    int i = int'(a[7:2]);
    logic [31:0] m;
    if (i == 0) begin
      if (s[0]) m_ctrl = d[1:0];
    end else if (i == 1 || i == 3 || i == 4 || i == 5) begin
      m = sx(m_reg[i]);
      for (int b = 0; b < 4; b++) if (s[b]) m[8*b +: 8] = d[8*b +: 8];
      m_reg[i] = m[15:0];
    end
  endtask

  // mode 0: AW and W together, 1: AW first, 2: W first
  task automatic axi_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                        input int mode, input int bhold);
    bit aw_done = 0, w_done = 0, aw_acc = 0, w_acc = 0;
    int cyc = 0;
    bready = (bhold == 0);
    while (!(aw_done && w_done)) begin
      @(negedge clk);
      if (aw_acc) aw_done = 1;
      if (w_acc)  w_done  = 1;
      awaddr  = a; wdata = d; wstrb = s;
      awvalid = !aw_done && cyc >= ((mode == 2) ? 3 : 0);
      wvalid  = !w_done  && cyc >= ((mode == 1) ? 3 : 0);
      #1;
      aw_acc = awvalid && awready;
      w_acc  = wvalid && wready;
      cyc++;
    end
    while (!bvalid) @(negedge clk);
    model_wr(a, d, s);
    check(bresp == 2'b00, "R9 bresp", 32'(bresp), 32'h0);
    for (int h = 0; h < bhold; h++) begin
      @(negedge clk);
      check(bvalid == 1'b1, "R9 bvalid held", 32'(bvalid), 32'h1);
    end
    bready = 1;
    @(negedge clk);
    check(bvalid == 1'b0, "R9 single response", 32'(bvalid), 32'h0);
  endtask

  task automatic axi_rd(input logic [7:0] a, input int rhold, input string req);
    logic [31:0] e;
    @(negedge clk);
    rready = (rhold == 0);
    araddr = a; arvalid = 1;
    e = exp_rd(a);
    #1;
    while (!arready) begin @(negedge clk); #1; end
    @(negedge clk);
    arvalid = 0;
    check(rvalid == 1'b1, "R11 rvalid", 32'(rvalid), 32'h1);
    check(rdata == e, req, rdata, e);
    check(rresp == 2'b00, "R11 rresp", 32'(rresp), 32'h0);
    for (int h = 0; h < rhold; h++) begin
      @(negedge clk);
      check(rvalid == 1'b1 && rdata == e, "R11 rdata held", rdata, e);
    end
    rready = 1;
    @(negedge clk);
    check(rvalid == 1'b0, "R11 single response", 32'(rvalid), 32'h0);
  endtask

  task automatic spikes(input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); spike = 1;
      for (int g = 0; g < gap; g++) begin @(negedge clk); spike = 0; end
    end
    @(negedge clk); spike = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL R9 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check({core_en, core_rst, irq} == 3'b0, "R1 outputs", 32'({core_en, core_rst, irq}), 32'h0);
    check({cur, rest, thr, tau} == '0, "R1 params", 32'(cur ^ rest ^ thr ^ tau), 32'h0);
    check(!bvalid && !rvalid, "R1 no response", 32'({bvalid, rvalid}), 32'h0);
    for (int i = 0; i < 6; i++) axi_rd(8'(4 * i), 0, "R1 reset read");
    // R2 / R9 writes in each order
    axi_wr(8'h04, 32'h0000_0150, 4'hF, 0, 0);
    axi_wr(8'h0C, 32'hFFFF_BF00, 4'hF, 1, 0);
    axi_wr(8'h10, 32'hFFFF_CE00, 4'hF, 2, 0);
    axi_wr(8'h14, 32'h0000_0A00, 4'hF, 1, 3);
    axi_rd(8'h04, 0, "R2 current");
    axi_rd(8'h0C, 0, "R2 rest sign-extended");
    axi_rd(8'h10, 2, "R2 threshold");
    axi_rd(8'h17, 0, "R2 low address bits ignored");
    // R10 byte strobes
    axi_wr(8'h04, 32'h0000_1234, 4'hF, 0, 0);
    axi_wr(8'h04, 32'h5566_AB77, 4'b0010, 0, 0);
    axi_rd(8'h04, 0, "R10 lane 1 only");
    axi_wr(8'h04, 32'hFFFF_FFFF, 4'b1100, 2, 0);
    axi_rd(8'h04, 0, "R10 upper lanes dropped");
    // R7 ignored writes, unmapped reads
    axi_wr(8'h08, 32'hDEAD_BEEF, 4'hF, 0, 0);
    axi_rd(8'h08, 0, "R7 count write ignored");
    axi_wr(8'h18, 32'hFFFF_FFFF, 4'hF, 0, 0);
    axi_rd(8'h18, 0, "R7 unmapped read zero");
    axi_rd(8'h3C, 0, "R7 unmapped read zero");
    // R4 / R8 disabled core ignores spikes
    spikes(4, 1);
    axi_rd(8'h08, 0, "R4 disabled no count");
    // R3 control word, other bits read zero
    axi_wr(8'h00, 32'hFFFF_FFFD, 4'hF, 0, 0);
    axi_rd(8'h00, 0, "R3 ctrl readback");
    spikes(5, 0);
    spikes(3, 2);
    axi_rd(8'h08, 0, "R4 enabled count");
    // R5 reset bit clears and holds counter
    axi_wr(8'h00, 32'h3, 4'h1, 0, 0);
    spikes(6, 0);
    axi_rd(8'h08, 0, "R5 held at zero");
    axi_wr(8'h00, 32'h1, 4'h1, 1, 0);
    spikes(2, 1);
    axi_rd(8'h08, 1, "R5 counts after release");
    axi_wr(8'h00, 32'h2, 4'h1, 2, 0);
    axi_rd(8'h08, 0, "R5 clear with enable off");
    axi_wr(8'h00, 32'h1, 4'h1, 0, 0);
    // R6 saturation
    spikes(300, 0);
    axi_rd(8'h08, 0, "R6 saturated");
    check(m_cnt == '1, "R6 model at max", 32'(m_cnt), 32'hFF);
    spikes(3, 1);
    axi_rd(8'h08, 0, "R6 stays saturated");
    axi_wr(8'h00, 32'h0, 4'h1, 0, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule